// File: doc/BRIEF.md
# Per-Level Interrupt Vector Acceptance Latch

This block is the receive side of a local interrupt controller. Each delivery request carries an 8-bit vector. The block files the vector under a priority level, which is the vector's upper four bits, so there are sixteen levels. Every level has only two latch slots. A request is accepted while its level still has a free slot, or when the vector is already latched. Otherwise the request is refused until the core retires one of that level's vectors.

On the core side, the block always offers the highest latched vector. It picks the highest level first and then the highest vector within that level. An end-of-interrupt pulse retires the offered vector.

On the sending side, the block watches the accept/reject answers to the interrupts it has sent. A refusal sets a sticky send-accept error bit, which stays set until a clear strobe. A controller may send an interrupt to itself. The answer wires can therefore be looped straight back from this block's own response outputs.

Top module: `vec_level_latch`

## Requirements
- R1: The level of a vector is `req_vec[7:4]`. Levels never share slots: with 0x30 and 0x3A latched, a request for 0x45 is accepted.
- R2: Each level holds at most two distinct vectors. A third distinct vector of a full level is answered with `rsp_accept`=0 and is not latched.
- R3: A request for a vector that is already latched is answered with `rsp_accept`=1 and uses no further slot. This also holds when its level is full.
- R4: A refusal seen on the send side (`tx_rsp_valid`=1, `tx_rsp_accept`=0) sets `err_status` bit 2 (value 0x04) at the next clock edge. An accepted answer leaves it unchanged.
- R5: When the response outputs are looped back to the send-side inputs, a refused request sets `err_status` to 0x04 two edges after it was taken.
- R6: A request is taken at a clock edge where `req_valid` and `req_ready` are both 1, and its answer appears on `rsp_valid`/`rsp_accept` right after that edge. While `rsp_valid`=1 and `rsp_ready`=0, the answer holds, `req_ready` is 0, and no request is taken.
- R7: `core_vec` is the highest latched vector, chosen by highest level first and then by highest vector within that level. When nothing is latched, `core_valid`=0 and `core_vec`=0.
- R8: When `eoi` is 1 at an edge, the offered vector is removed by that edge. A request of the same level taken at the same edge sees the freed slot.
- R9: `err_status` bit 2 is sticky. It is cleared only by `err_clr`. A refusal arriving at the same edge as `err_clr` wins. All other `err_status` bits read 0.
- R10: After reset, nothing is latched, `err_status`=0, `rsp_valid`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Delivery request present |
| req_vec | input | 8 | Requested vector |
| req_ready | output | 1 | Block can take a request this cycle |
| rsp_valid | output | 1 | Answer to the last taken request present |
| rsp_accept | output | 1 | 1 = accepted, 0 = refused |
| rsp_ready | input | 1 | Requester takes the answer |
| core_valid | output | 1 | At least one vector latched |
| core_vec | output | 8 | Highest latched vector |
| eoi | input | 1 | End of service for `core_vec` |
| tx_rsp_valid | input | 1 | Answer to this controller's own send present |
| tx_rsp_accept | input | 1 | That answer was an accept |
| err_clr | input | 1 | Clear strobe for the error status |
| err_status | output | 8 | Error status; bit 2 = send-accept error |

## Verification
The retire property assumes that no request is taken in the cycle of an `eoi`, because a taken request could re-latch the same vector. The directed stimulus therefore checks the one case that combines `eoi` with a request separately, and through the ports. The error properties assume that `tx_rsp_valid` and `err_clr` are sampled at the same edge. The bench drives both only on falling edges. The hold property relies on the requester keeping `rsp_ready` low for whole cycles. The bench also offers a request while the block is stalled, to show that it is not taken.

// File: rtl/vll_pkg.sv
package vll_pkg;
   typedef struct packed {
      logic valid;
      logic accept;
   } vll_rsp_t;

   localparam int unsigned VLL_ERR_SEND_ACCEPT = 2;
endpackage

// File: rtl/vll_level_bank.sv
module vll_level_bank #(
   parameter int unsigned LO_W  = 4,
   parameter int unsigned SLOTS = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr_en,
   input  logic [LO_W-1:0] clr_lo,
   input  logic            wr_en,
   input  logic [LO_W-1:0] q_lo,
   output logic            q_hit,
   output logic            q_free,
   output logic            top_valid,
   output logic [LO_W-1:0] top_lo
);
   logic [SLOTS-1:0] vld_q;
   logic [LO_W-1:0]  lo_q [SLOTS];
   logic [SLOTS-1:0] keep;
   logic [SLOTS-1:0] match;
   logic [SLOTS-1:0] ins_oh;
   logic             do_ins;

   always_comb begin
      for (int s = 0; s < SLOTS; s++) begin
         keep[s]  = vld_q[s] & ~(clr_en && (lo_q[s] == clr_lo));
         match[s] = keep[s] & (lo_q[s] == q_lo);
      end
   end

   assign q_hit  = |match;
   assign q_free = |(~keep);
   assign do_ins = wr_en & ~q_hit;

   generate
      if (SLOTS == 1) begin : g_single
         assign ins_oh = ~keep;
      end else begin : g_multi
         always_comb begin
            logic found;
            found  = 1'b0;
            ins_oh = '0;
            for (int s = 0; s < SLOTS; s++) begin
               if (!keep[s] && !found) begin
                  ins_oh[s] = 1'b1;
                  found     = 1'b1;
               end
            end
         end
      end
   endgenerate

   always_comb begin
      top_valid = 1'b0;
      top_lo    = '0;
      for (int s = 0; s < SLOTS; s++) begin
         if (vld_q[s] && (!top_valid || lo_q[s] > top_lo)) begin
            top_lo    = lo_q[s];
            top_valid = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int s = 0; s < SLOTS; s++) lo_q[s] <= '0;
      end else begin
         vld_q <= keep | (do_ins ? ins_oh : '0);
         for (int s = 0; s < SLOTS; s++) begin
            if (do_ins && ins_oh[s]) lo_q[s] <= q_lo;
         end
      end
   end
endmodule

// File: rtl/vll_prio_pick.sv
module vll_prio_pick #(
   parameter int unsigned N     = 16,
   parameter int unsigned IDX_W = 4
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i]) begin
            any = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/vll_err_status.sv
module vll_err_status #(
   parameter int unsigned ERR_W   = 8,
   parameter int unsigned ERR_BIT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rej_evt,
   input  logic             clr,
   output logic [ERR_W-1:0] status
);
   generate
      for (genvar b = 0; b < ERR_W; b++) begin : g_bit
         if (b == ERR_BIT) begin : g_sticky
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)       status[b] <= 1'b0;
               else if (rej_evt) status[b] <= 1'b1;
               else if (clr)     status[b] <= 1'b0;
            end
         end else begin : g_zero
            assign status[b] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/vec_level_latch.sv
module vec_level_latch
   import vll_pkg::*;
#(
   parameter int unsigned VEC_W   = 8,
   parameter int unsigned LVL_W   = 4,
   parameter int unsigned SLOTS   = 2,
   parameter int unsigned ERR_W   = 8,
   parameter int unsigned ERR_BIT = VLL_ERR_SEND_ACCEPT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [VEC_W-1:0] req_vec,
   output logic             req_ready,
   output logic             rsp_valid,
   output logic             rsp_accept,
   input  logic             rsp_ready,
   output logic             core_valid,
   output logic [VEC_W-1:0] core_vec,
   input  logic             eoi,
   input  logic             tx_rsp_valid,
   input  logic             tx_rsp_accept,
   input  logic             err_clr,
   output logic [ERR_W-1:0] err_status
);
   localparam int unsigned LVLS = 1 << LVL_W;
   localparam int unsigned LO_W = VEC_W - LVL_W;

   generate
      if (LVL_W < 1 || LVL_W >= VEC_W) begin : g_bad_lvl
         $error("LVL_W must be between 1 and VEC_W-1");
      end
      if (SLOTS < 1) begin : g_bad_slots
         $error("SLOTS must be at least 1");
      end
      if (ERR_BIT >= ERR_W) begin : g_bad_err
         $error("ERR_BIT must lie inside ERR_W");
      end
   endgenerate

   logic [LVL_W-1:0] req_lvl;
   logic [LO_W-1:0]  req_lo;
   logic             take;
   logic             acc;
   logic [LVLS-1:0]  hit_v;
   logic [LVLS-1:0]  free_v;
   logic [LVLS-1:0]  top_vld_v;
   logic [LO_W-1:0]  top_lo_a [LVLS];
   logic [LVL_W-1:0] core_lvl;
   logic [LO_W-1:0]  core_lo;
   logic             retire;
   vll_rsp_t         rsp_q;

   assign req_lvl = req_vec[VEC_W-1 -: LVL_W];
   assign req_lo  = req_vec[LO_W-1:0];
   assign req_ready = ~rsp_q.valid | rsp_ready;
   assign take    = req_valid & req_ready;
   assign acc     = hit_v[req_lvl] | free_v[req_lvl];
   assign retire  = eoi & core_valid;

   generate
      for (genvar l = 0; l < LVLS; l++) begin : g_lvl
         vll_level_bank #(.LO_W(LO_W), .SLOTS(SLOTS)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_en    (retire && (core_lvl == LVL_W'(l))),
            .clr_lo    (core_lo),
            .wr_en     (take && acc && (req_lvl == LVL_W'(l))),
            .q_lo      (req_lo),
            .q_hit     (hit_v[l]),
            .q_free    (free_v[l]),
            .top_valid (top_vld_v[l]),
            .top_lo    (top_lo_a[l])
         );
      end
   endgenerate

   vll_prio_pick #(.N(LVLS), .IDX_W(LVL_W)) u_pick (
      .req (top_vld_v),
      .any (core_valid),
      .idx (core_lvl)
   );

   assign core_lo  = top_lo_a[core_lvl];
   assign core_vec = core_valid ? {core_lvl, core_lo} : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_q <= '0;
      end else if (take) begin
         rsp_q.valid  <= 1'b1;
         rsp_q.accept <= acc;
      end else if (rsp_ready) begin
         rsp_q.valid <= 1'b0;
      end
   end

   assign rsp_valid  = rsp_q.valid;
   assign rsp_accept = rsp_q.accept;

   vll_err_status #(.ERR_W(ERR_W), .ERR_BIT(ERR_BIT)) u_err (
      .clk     (clk),
      .rst_n   (rst_n),
      .rej_evt (tx_rsp_valid & ~tx_rsp_accept),
      .clr     (err_clr),
      .status  (err_status)
   );
endmodule

// File: rtl/vll_checker.sv
module vll_checker #(
   parameter int unsigned VEC_W   = 8,
   parameter int unsigned ERR_W   = 8,
   parameter int unsigned ERR_BIT = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [VEC_W-1:0] req_vec,
   input logic             req_ready,
   input logic             rsp_valid,
   input logic             rsp_accept,
   input logic             rsp_ready,
   input logic             core_valid,
   input logic [VEC_W-1:0] core_vec,
   input logic             eoi,
   input logic             tx_rsp_valid,
   input logic             tx_rsp_accept,
   input logic             err_clr,
   input logic [ERR_W-1:0] err_status
);
   // R6: a taken request is answered right after the edge
   p_rsp_after_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid);

   // R6: a stalled answer holds its value
   p_rsp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_accept)));

   // R4: a refusal on the send side raises the error bit
   p_err_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_rsp_valid && !tx_rsp_accept) |=> err_status[ERR_BIT]);

   // R9: the error bit survives until a clear
   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_status[ERR_BIT] && !err_clr) |=> err_status[ERR_BIT]);

   // R9: a clear with no refusal drops the error bit
   p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_clr && !(tx_rsp_valid && !tx_rsp_accept)) |=> !err_status[ERR_BIT]);

   // R8: a retired vector is no longer offered
   p_eoi_retire_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && core_valid && !(req_valid && req_ready))
      |=> (!core_valid || core_vec != $past(core_vec)));
endmodule

bind vec_level_latch vll_checker #(
   .VEC_W(VEC_W), .ERR_W(ERR_W), .ERR_BIT(ERR_BIT)
) u_vll_chk (.*);

// File: tb/vec_level_latch_tb_top.sv
module vec_level_latch_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [7:0] req_vec = '0;
   logic       req_ready;
   logic       rsp_valid;
   logic       rsp_accept;
   logic       rsp_ready = 1'b1;
   logic       core_valid;
   logic [7:0] core_vec;
   logic       eoi = 1'b0;
   logic       tx_rsp_valid;
   logic       tx_rsp_accept;
   logic       err_clr = 1'b0;
   logic [7:0] err_status;
   logic       loop_en = 1'b1;
   logic       tx_v_drv = 1'b0;
   logic       tx_a_drv = 1'b0;
   int         n_checks = 0;
   int         n_errors = 0;

   always #2 clk = ~clk;

   assign tx_rsp_valid  = loop_en ? rsp_valid  : tx_v_drv;
   assign tx_rsp_accept = loop_en ? rsp_accept : tx_a_drv;

   vec_level_latch dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_vec(req_vec), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_accept(rsp_accept), .rsp_ready(rsp_ready),
      .core_valid(core_valid), .core_vec(core_vec), .eoi(eoi),
      .tx_rsp_valid(tx_rsp_valid), .tx_rsp_accept(tx_rsp_accept),
      .err_clr(err_clr), .err_status(err_status)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] v, input logic exp_acc, input string tag);
      @(negedge clk);
      chk({tag, " ready"}, {7'd0, req_ready}, 8'd1);
      req_valid = 1'b1;
      req_vec   = v;
      @(posedge clk); #1;
      chk({tag, " rsp_valid"}, {7'd0, rsp_valid}, 8'd1);
      chk({tag, " accept"}, {7'd0, rsp_accept}, {7'd0, exp_acc});
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic retire(input logic [7:0] exp_vec, input string tag);
      @(negedge clk);
      eoi = 1'b1;
      @(posedge clk); #1;
      chk({tag, " core_vec"}, core_vec, exp_vec);
      @(negedge clk);
      eoi = 1'b0;
   endtask

   task automatic t_reset;
      chk("R10 core_valid", {7'd0, core_valid}, 8'd0);
      chk("R7 empty core_vec", core_vec, 8'h00);
      chk("R10 err_status", err_status, 8'h00);
      chk("R10 rsp_valid", {7'd0, rsp_valid}, 8'd0);
      chk("R10 req_ready", {7'd0, req_ready}, 8'd1);
   endtask

   task automatic t_levels;
      send(8'h30, 1'b1, "R2 first slot");
      send(8'h3A, 1'b1, "R2 second slot");
      send(8'h45, 1'b1, "R1 other level");
      chk("R7 highest level", core_vec, 8'h45);
      send(8'h3C, 1'b0, "R2 level full");
      @(posedge clk); #1;
      chk("R5 loopback error", err_status, 8'h04);
      send(8'h30, 1'b1, "R3 duplicate");
      chk("R3 core unchanged", core_vec, 8'h45);
      retire(8'h3A, "R8 retire 45");
      retire(8'h30, "R8 retire 3A");
      send(8'h31, 1'b1, "R3 dup used no slot");
      send(8'h3F, 1'b0, "R2 refill full");
      chk("R7 highest in level", core_vec, 8'h31);
      send(8'h31, 1'b1, "R3 dup at full level");
   endtask

   task automatic t_eoi_same;
      @(negedge clk);
      eoi = 1'b1; req_valid = 1'b1; req_vec = 8'h3F;
      @(posedge clk); #1;
      chk("R8 same-cycle accept", {7'd0, rsp_accept}, 8'd1);
      chk("R8 same-cycle core", core_vec, 8'h3F);
      @(negedge clk);
      eoi = 1'b0; req_valid = 1'b0;
   endtask

   task automatic t_err;
      @(negedge clk);
      loop_en = 1'b0; err_clr = 1'b1;
      @(posedge clk); #1;
      chk("R9 clear", err_status, 8'h00);
      @(negedge clk);
      err_clr = 1'b0; tx_v_drv = 1'b1; tx_a_drv = 1'b1;
      @(posedge clk); #1;
      chk("R4 accept no error", err_status, 8'h00);
      @(negedge clk);
      tx_a_drv = 1'b0;
      @(posedge clk); #1;
      chk("R4 refusal sets", err_status, 8'h04);
      @(negedge clk);
      tx_v_drv = 1'b0;
      @(posedge clk); #1;
      chk("R9 sticky", err_status, 8'h04);
      @(negedge clk);
      err_clr = 1'b1;
      @(posedge clk); #1;
      chk("R9 clear again", err_status, 8'h00);
      @(negedge clk);
      tx_v_drv = 1'b1;
      @(posedge clk); #1;
      chk("R9 set wins over clear", err_status, 8'h04);
      @(negedge clk);
      tx_v_drv = 1'b0;
      @(posedge clk); #1;
      chk("R9 final clear", err_status, 8'h00);
      @(negedge clk);
      err_clr = 1'b0; loop_en = 1'b1;
   endtask

   task automatic t_stall;
      @(negedge clk);
      rsp_ready = 1'b0;
      req_valid = 1'b1; req_vec = 8'h50;
      @(posedge clk); #1;
      chk("R6 stall accept", {7'd0, rsp_accept}, 8'd1);
      chk("R6 stall ready low", {7'd0, req_ready}, 8'd0);
      @(negedge clk);
      req_vec = 8'h3E;
      @(posedge clk); #1;
      chk("R6 answer held", {6'd0, rsp_valid, rsp_accept}, 8'd3);
      chk("R7 core level 5", core_vec, 8'h50);
      @(negedge clk);
      req_valid = 1'b0; rsp_ready = 1'b1;
      @(posedge clk); #1;
      chk("R6 answer drained", {7'd0, rsp_valid}, 8'd0);
      chk("R5 no error on accept", err_status, 8'h00);
   endtask

   task automatic t_drain;
      retire(8'h3F, "R8 drain 50");
      retire(8'h30, "R6 stalled 3E not latched");
      retire(8'h00, "R7 empty after drain");
      chk("R7 core_valid low", {7'd0, core_valid}, 8'd0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_levels();
      t_eoi_same();
      t_err();
      t_stall();
      t_drain();
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end
endmodule